// File: doc/BRIEF.md
# Landing Gear Retraction Controller

This block sequences a hydraulic landing-gear actuator from a pilot lever and three sensors. These are weight on the ground, gear fully stowed and gear fully extended. It is a Moore machine with six states, and a countdown timer sits beside it. The timer enforces a minimum airborne interval before retraction may begin. Every output (valve direction, pump enable, timer clear, red and green lamps) is a pure function of the present state. Outputs that the control law leaves unspecified are driven low.

After takeoff the controller waits in an airborne state while the timer runs down. The length of that wait is `CLK_PER_SEC * 2` clock cycles. Retraction starts only once the timer has expired and the lever asks for gear up. Touching down before then sends the machine back to the ground state, and the wait starts over. The gear is then stowed, lowered on command and reported down. A lever that already reads "up" at power-up is honoured: the gear retracts after takeoff and the wait, with no lever movement needed.

Top module: `gear_ctrl_top`

## Requirements
- R1: While reset is asserted, and directly after it, the outputs {timer_clr, pump, valve, red, green} equal 10001. This is the ground-wait state.
- R2: The outputs per state are as follows, in the order {timer_clr, pump, valve, red, green}: ground-wait 10001, air-wait 00001, raising 01010, stowed 00000, lowering 01110, deployed 00001. Valve 1 means lowering, and pump 1 runs the pump.
- R3: In ground-wait, on_ground=0 at a rising edge moves the machine to air-wait. While on_ground=1 it stays in ground-wait.
- R4: In air-wait, on_ground=1 at an edge returns the machine to ground-wait, which clears the timer. A later takeoff restarts the full wait.
- R5: Raising is entered only from air-wait, with the timer expired and lever_dn=0. The pump first turns on exactly TICKS+1 rising edges after the edge that entered air-wait, where TICKS = CLK_PER_SEC*2.
- R6: In air-wait with the timer expired, lever_dn=1 holds the state. The edge at which lever_dn becomes 0 enters raising.
- R7: Raising moves to stowed when gear_up=1. Lever changes during raising have no effect.
- R8: Stowed moves to lowering when lever_dn=1. With lever_dn=0 it stays stowed.
- R9: Lowering moves to deployed when gear_dn=1, and stays in lowering until then.
- R10: Deployed moves to ground-wait when lever_dn=0. The ground sensor has no effect in deployed.
- R11: With lever_dn=0 from reset, the machine stays in ground-wait while on the ground. It retracts after takeoff plus the wait, with no change of the lever.
- R12: The red and green lamps are never lit together, and the pump never runs with the red lamp off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lever_dn_i | input | 1 | Pilot lever, 1 = gear down, 0 = gear up |
| on_ground_i | input | 1 | Weight-on-ground sensor, 1 = on ground |
| gear_up_i | input | 1 | Gear fully stowed sensor |
| gear_dn_i | input | 1 | Gear fully extended sensor |
| valve_lower_o | output | 1 | Valve direction, 1 = lowering, 0 = raising |
| pump_on_o | output | 1 | Hydraulic pump enable |
| timer_clr_o | output | 1 | Holds the airborne timer at its full count |
| lamp_red_o | output | 1 | Gear-in-motion lamp |
| lamp_green_o | output | 1 | Gear-down / safe lamp |

## Verification
Every output is decoded from the state register, so a sensor or lever change sampled at one rising edge shows on the outputs right after that same edge. The bench drives inputs on the falling edge and compares outputs shortly after the next rising edge. The timed path counts rising edges from the falling-edge drive of takeoff. The first edge enters air-wait, and the pump must first appear on edge TICKS+2 of that count and not one edge earlier. This is checked once from a lever held up at power-up and once after an aborted takeoff.

// File: rtl/gear_pkg.sv
`timescale 1ns/1ps
package gear_pkg;

  typedef enum logic [2:0] {
    ST_GROUND_WAIT = 3'd0,
    ST_AIR_WAIT    = 3'd1,
    ST_RAISE       = 3'd2,
    ST_STOWED      = 3'd3,
    ST_LOWER       = 3'd4,
    ST_DEPLOYED    = 3'd5
  } gear_state_e;

  typedef struct packed {
    logic timer_clr;
    logic pump;
    logic valve;
    logic red;
    logic green;
  } gear_drive_t;

  // Length of the airborne wait in clock cycles.
  function automatic int unsigned hold_ticks(int unsigned cps, int unsigned secs);
    return cps * secs;
  endfunction

  // Moore output law; unspecified outputs are forced low.
  function automatic gear_drive_t gear_drive(gear_state_e st);
    gear_drive_t d;
    d = '0;
    case (st)
      ST_GROUND_WAIT: begin d.timer_clr = 1'b1; d.green = 1'b1; end
      ST_AIR_WAIT:    d.green = 1'b1;
      ST_RAISE:       begin d.pump = 1'b1; d.red = 1'b1; end
      ST_STOWED:      d = '0;
      ST_LOWER:       begin d.pump = 1'b1; d.valve = 1'b1; d.red = 1'b1; end
      ST_DEPLOYED:    d.green = 1'b1;
      default:        d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gear_timer.sv
`timescale 1ns/1ps
module gear_timer #(
  parameter int unsigned CLK_PER_SEC = 1000,
  parameter int unsigned HOLD_SEC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned TICKS = gear_pkg::hold_ticks(CLK_PER_SEC, HOLD_SEC);
  localparam int unsigned CW    = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(TICKS);
    end else if (clear_i) begin
      cnt_q <= CW'(TICKS);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/gear_fsm.sv
`timescale 1ns/1ps
module gear_fsm
  import gear_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lever_dn_i,
  input  logic        on_ground_i,
  input  logic        gear_up_i,
  input  logic        gear_dn_i,
  input  logic        time_up_i,
  output gear_state_e state_o
);
  gear_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_GROUND_WAIT: if (!on_ground_i) state_d = ST_AIR_WAIT;
      ST_AIR_WAIT: begin
        if (on_ground_i)                  state_d = ST_GROUND_WAIT;
        else if (time_up_i && !lever_dn_i) state_d = ST_RAISE;
      end
      ST_RAISE:    if (gear_up_i)  state_d = ST_STOWED;
      ST_STOWED:   if (lever_dn_i) state_d = ST_LOWER;
      ST_LOWER:    if (gear_dn_i)  state_d = ST_DEPLOYED;
      ST_DEPLOYED: if (!lever_dn_i) state_d = ST_GROUND_WAIT;
      default:     state_d = ST_GROUND_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_GROUND_WAIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/gear_decode.sv
`timescale 1ns/1ps
module gear_decode
  import gear_pkg::*;
(
  input  gear_state_e state_i,
  output gear_drive_t drive_o
);
  always_comb drive_o = gear_drive(state_i);
endmodule

// File: rtl/gear_ctrl_top.sv
`timescale 1ns/1ps
module gear_ctrl_top
  import gear_pkg::*;
#(
  parameter int unsigned CLK_PER_SEC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lever_dn_i,
  input  logic on_ground_i,
  input  logic gear_up_i,
  input  logic gear_dn_i,
  output logic valve_lower_o,
  output logic pump_on_o,
  output logic timer_clr_o,
  output logic lamp_red_o,
  output logic lamp_green_o
);
  localparam int unsigned HOLD_SEC = 2;
  localparam int unsigned TICKS    = hold_ticks(CLK_PER_SEC, HOLD_SEC);

  gear_state_e state_q;
  gear_drive_t drive;
  logic        time_up;   // timer -> fsm
  logic        timer_clr; // decode -> timer

  gear_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lever_dn_i  (lever_dn_i),
    .on_ground_i (on_ground_i),
    .gear_up_i   (gear_up_i),
    .gear_dn_i   (gear_dn_i),
    .time_up_i   (time_up),
    .state_o     (state_q)
  );

  gear_decode u_dec (
    .state_i (state_q),
    .drive_o (drive)
  );

  assign timer_clr = drive.timer_clr;

  gear_timer #(.CLK_PER_SEC(CLK_PER_SEC), .HOLD_SEC(HOLD_SEC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (timer_clr),
    .expired_o (time_up)
  );

  assign timer_clr_o   = timer_clr;
  assign pump_on_o     = drive.pump;
  assign valve_lower_o = drive.valve;
  assign lamp_red_o    = drive.red;
  assign lamp_green_o  = drive.green;
endmodule

// File: rtl/gear_ctrl_chk.sv
`timescale 1ns/1ps
module gear_ctrl_chk
  import gear_pkg::*;
#(
  parameter int unsigned TICKS = 2000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input gear_state_e state_q,
  input logic        time_up,
  input logic        timer_clr,
  input logic        lever_dn_i,
  input logic        on_ground_i,
  input logic        gear_dn_i,
  input logic        pump_on_o,
  input logic        lamp_red_o,
  input logic        lamp_green_o
);
  localparam int unsigned AW = $clog2(TICKS + 2);
  localparam logic [AW-1:0] AMAX = AW'(TICKS + 1);

  // Consecutive cycles spent in air-wait, saturating.
  logic [AW-1:0] air_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      air_cnt <= '0;
    else if (state_q != ST_AIR_WAIT)  air_cnt <= '0;
    else if (air_cnt != AMAX)         air_cnt <= air_cnt + 1'b1;
  end

  p_airborne_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAISE && $past(state_q) == ST_AIR_WAIT) |-> (air_cnt >= AW'(TICKS)));

  p_raise_interlock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAISE && $past(state_q) != ST_RAISE) |->
      ($past(time_up) && !$past(lever_dn_i) && !$past(on_ground_i)));

  p_clear_blocks_expiry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_clr |=> !time_up);

  p_touchdown_return_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AIR_WAIT && on_ground_i) |=> (state_q == ST_GROUND_WAIT));

  p_down_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOWER && gear_dn_i) |=> (state_q == ST_DEPLOYED));

  p_lamps_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lamp_red_o && lamp_green_o));

  p_pump_shows_red_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_on_o |-> lamp_red_o);
endmodule

bind gear_ctrl_top gear_ctrl_chk #(.TICKS(TICKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_q      (state_q),
  .time_up      (time_up),
  .timer_clr    (timer_clr),
  .lever_dn_i   (lever_dn_i),
  .on_ground_i  (on_ground_i),
  .gear_dn_i    (gear_dn_i),
  .pump_on_o    (pump_on_o),
  .lamp_red_o   (lamp_red_o),
  .lamp_green_o (lamp_green_o)
);

// File: tb/gear_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module gear_ctrl_top_tb_top;
  localparam int unsigned CPS   = 4;
  localparam int unsigned TICKS = CPS * 2;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lever_dn = 1'b1, on_ground = 1'b1, gear_up = 1'b0, gear_dn = 1'b1;
  logic valve_lower, pump_on, timer_clr, lamp_red, lamp_green;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gear_ctrl_top #(.CLK_PER_SEC(CPS)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .lever_dn_i    (lever_dn),
    .on_ground_i   (on_ground),
    .gear_up_i     (gear_up),
    .gear_dn_i     (gear_dn),
    .valve_lower_o (valve_lower),
    .pump_on_o     (pump_on),
    .timer_clr_o   (timer_clr),
    .lamp_red_o    (lamp_red),
    .lamp_green_o  (lamp_green)
  );

  // Output word {timer_clr, pump, valve, red, green}, per state (R2).
  localparam logic [4:0] O_GW = 5'b10001, O_AW = 5'b00001, O_RG = 5'b01010,
                         O_ST = 5'b00000, O_LG = 5'b01110, O_DP = 5'b00001;

  // Vector: {lever_dn, on_ground, gear_up, gear_dn, expected outputs}
  localparam logic [8:0] VEC [NV] = '{
    {4'b1101, O_GW},  // R3 on ground: stay
    {4'b1001, O_AW},  // R3 takeoff
    {4'b1101, O_GW},  // R4 touchdown
    {4'b1001, O_AW},  // R3 takeoff again, timer starts
    {4'b1000, O_AW}, {4'b1000, O_AW}, {4'b1000, O_AW}, {4'b1000, O_AW},
    {4'b1000, O_AW}, {4'b1000, O_AW}, {4'b1000, O_AW}, {4'b1000, O_AW},
    {4'b1000, O_AW}, {4'b1000, O_AW},  // R6 expired but lever down: hold
    {4'b0000, O_RG},  // R6 lever up -> raising
    {4'b1000, O_RG},  // R7 lever ignored while raising
    {4'b1010, O_ST},  // R7 stowed
    {4'b0010, O_ST},  // R8 lever up: stay stowed
    {4'b1000, O_LG},  // R8 lever down -> lowering
    {4'b1000, O_LG},  // R9 not down yet
    {4'b1001, O_DP},  // R9 deployed
    {4'b1101, O_DP},  // R10 ground sensor ignored
    {4'b0101, O_GW}   // R10 lever up -> ground-wait
  };
  localparam int VREQ [NV] = '{3,3,4,3,6,6,6,6,6,6,6,6,6,6,6,7,7,8,8,9,9,10,10};

  function automatic logic [4:0] outs();
    return {timer_clr, pump_on, valve_lower, lamp_red, lamp_green};
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lev);
    @(negedge clk);
    rst_n = 1'b0; lever_dn = lev; on_ground = 1'b1; gear_up = 1'b0; gear_dn = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Edges from takeoff drive until pump first seen; 0 if never.
  task automatic time_to_pump(output int first);
    first = 0;
    @(negedge clk);
    on_ground = 1'b0;
    for (int n = 1; n <= TICKS + 6; n++) begin
      @(posedge clk); #1;
      if (pump_on && first == 0) first = n;
    end
  endtask

  initial begin
    int first;
    #1;
    // R1: reset state
    check("R1 during reset", outs(), O_GW);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", outs(), O_GW);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {lever_dn, on_ground, gear_up, gear_dn} = VEC[i][8:5];
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VREQ[i], i), outs(), VEC[i][4:0]);
      checks++;
      if (lamp_red && lamp_green) begin
        fails++;
        $display("FAIL R12 vector %0d: red=%b green=%b expected not both", i, lamp_red, lamp_green);
      end
    end

    // R11: lever up from reset, on ground: no retraction
    do_reset(1'b0);
    repeat (TICKS + 4) @(posedge clk);
    #1;
    check("R11 stays on ground with lever up", outs(), O_GW);
    // R5 / R11: exact airborne wait
    time_to_pump(first);
    check_int("R5 R11 edges to pump", first, TICKS + 2);

    // R4: aborted takeoff restarts the wait
    do_reset(1'b0);
    @(negedge clk); on_ground = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); on_ground = 1'b1;
    @(posedge clk); #1;
    check("R4 touchdown clears wait", outs(), O_GW);
    time_to_pump(first);
    check_int("R4 R5 edges to pump after abort", first, TICKS + 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule